// File: doc/BRIEF.md
# Banked Look-Up Table Access Port

This block holds four banks of byte-wide look-up tables: a red, a green and a blue output bank, plus an input bank. Each bank contains several equal-depth tables. A host reaches every table entry through three byte registers on a small register port: a control register, an entry-address register and a data window. The control register names the bank that the host is working on. It also holds two table-select fields. One chooses the live table in the input bank, and the other chooses the live table in all three colour banks.

Besides host access, the block has two pixel streams, each with valid/ready handshakes. The capture stream sends an incoming pixel through the live input table. The display stream sends a stored pixel through the live red, green and blue tables, which gives three colour bytes. Each stream has one register stage. A pixel is accepted when `in_valid` and `in_ready` are both high. Its result appears on the next cycle and stays on the outputs, unchanged, until `out_ready` is high. A stream only accepts a new pixel when its output register is empty or is being drained in that same cycle. A host write to a bank that a stream reads holds that stream off for the cycle of the write.

Top module: `lut_port`

## Requirements
- R1: The control register and the address register reset to 0. Each one is written as a full byte through `host_sel` 0 (control) and 1 (address), and reads back as written. `host_rdata` is 0 after reset. Writes with `host_sel` 3 change nothing, and reads with `host_sel` 3 return 0.
- R2: Control bits 1:0 choose the bank used by the data window (`host_sel` 2): 0 is red, 1 is green, 2 is blue and 3 is input.
- R3: Control bits 4:2 hold the input-table select. Only its low SEL_W bits are used. This select picks the table for host access when bank 3 is chosen, and it picks the table used by the capture stream.
- R4: Control bits 7:5 hold the output-table select. Only its low SEL_W bits are used. This select picks the table for host access to banks 0 to 2, and it picks the table used by the display stream.
- R5: The low ADDR_W bits of the address register choose the entry. Accesses through the data window never change the address register.
- R6: A read through the data window presents the chosen entry on `host_rdata` in the cycle after `host_rd` is high. A write through the data window stores `host_wdata` into that entry.
- R7: A capture pixel accepted in one cycle produces `cap_out_valid` in the next cycle. Its result on `cap_out_data` is the live input-table entry indexed by the low ADDR_W bits of the pixel.
- R8: A display pixel accepted in one cycle produces `disp_out_valid` in the next cycle. Its results on `disp_out_red`, `disp_out_green` and `disp_out_blue` are the entries of the live output table of banks 0, 1 and 2, indexed by the low ADDR_W bits of the pixel.
- R9: While an output is valid and its ready input is low, the output stays valid and its data stays unchanged. `in_ready` is high only when the output register is empty or `out_ready` is high.
- R10: In any cycle with a data-window write to bank 3, `cap_in_ready` is low. In any cycle with a data-window write to bank 0, 1 or 2, `disp_in_ready` is low. A pixel accepted after such a write sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data window, 3 none |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after the read strobe |
| cap_in_valid | input | 1 | Capture pixel valid |
| cap_in_ready | output | 1 | Capture pixel accepted |
| cap_in_data | input | 8 | Capture pixel |
| cap_out_valid | output | 1 | Capture result valid |
| cap_out_ready | input | 1 | Capture result taken |
| cap_out_data | output | 8 | Capture result |
| disp_in_valid | input | 1 | Display pixel valid |
| disp_in_ready | output | 1 | Display pixel accepted |
| disp_in_data | input | 8 | Stored pixel |
| disp_out_valid | output | 1 | Colour result valid |
| disp_out_ready | input | 1 | Colour result taken |
| disp_out_red | output | 8 | Red result |
| disp_out_green | output | 8 | Green result |
| disp_out_blue | output | 8 | Blue result |

## Verification
The bench builds the block with SEL_W = 2 and ADDR_W = 4. This gives four tables of sixteen entries per bank, or 256 entries in all. That is small enough to write and read back every entry of every table through the data window, and to push every pixel code through every live table on both streams. Because only two select bits are used, the bench can set the unused third select bit and use addresses above 15, which shows that the upper bits are ignored. The small depth also keeps the stall and back-pressure runs short enough to follow cycle by cycle.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } host_reg_e;

  localparam logic [1:0] BANK_INPUT = 2'd3;
  localparam int NUM_BANKS  = 4;
  localparam int IN_SEL_LSB  = 2;
  localparam int OUT_SEL_LSB = 5;
endpackage

// File: rtl/lut_regs.sv
module lut_regs
  import lut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else if (host_wr) begin
      if (host_sel == REG_CTRL) ctrl_q <= host_wdata;
      if (host_sel == REG_ADDR) addr_q <= host_wdata;
    end
  end

  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == REG_CTRL) |=> $stable(ctrl_q));

  assert_no_autoinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && host_sel == REG_DATA) |=> $stable(addr_q));
endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              hrd_en,
  input  logic [SEL_W-1:0]  h_tbl,
  input  logic [ADDR_W-1:0] h_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] hrd_q,
  input  logic              px_en,
  input  logic [SEL_W-1:0]  px_tbl,
  input  logic [ADDR_W-1:0] px_idx,
  output logic [DATA_W-1:0] px_q
);
  localparam int DEPTH = 1 << (SEL_W + ADDR_W);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)  mem[{h_tbl, h_idx}] <= wr_data;
    if (hrd_en) hrd_q <= mem[{h_tbl, h_idx}];
    if (px_en)  px_q  <= mem[{px_tbl, px_idx}];
  end
endmodule

// File: rtl/lut_pix_stage.sv
module lut_pix_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic block,
  input  logic out_ready,
  output logic in_ready,
  output logic fire,
  output logic out_valid
);
  assign in_ready = (!out_valid || out_ready) && !block;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (fire)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/lut_port.sv
module lut_port
  import lut_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              cap_in_valid,
  output logic              cap_in_ready,
  input  logic [BYTE_W-1:0] cap_in_data,
  output logic              cap_out_valid,
  input  logic              cap_out_ready,
  output logic [BYTE_W-1:0] cap_out_data,
  input  logic              disp_in_valid,
  output logic              disp_in_ready,
  input  logic [BYTE_W-1:0] disp_in_data,
  output logic              disp_out_valid,
  input  logic              disp_out_ready,
  output logic [BYTE_W-1:0] disp_out_red,
  output logic [BYTE_W-1:0] disp_out_green,
  output logic [BYTE_W-1:0] disp_out_blue
);
  logic [BYTE_W-1:0] ctrl_q, addr_q;
  logic [1:0]        bank;
  logic [SEL_W-1:0]  in_sel, out_sel, host_tbl;
  logic [ADDR_W-1:0] host_idx;
  logic              data_wr, data_rd;
  logic              cap_fire, disp_fire;
  logic              cap_block, disp_block;
  logic [BYTE_W-1:0] hrd_q [NUM_BANKS];
  logic [BYTE_W-1:0] px_q  [NUM_BANKS];

  lut_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .ctrl_q(ctrl_q), .addr_q(addr_q)
  );

  assign bank     = ctrl_q[1:0];
  assign in_sel   = ctrl_q[IN_SEL_LSB +: SEL_W];
  assign out_sel  = ctrl_q[OUT_SEL_LSB +: SEL_W];
  assign host_tbl = (bank == BANK_INPUT) ? in_sel : out_sel;
  assign host_idx = addr_q[ADDR_W-1:0];
  assign data_wr  = host_wr && (host_sel == REG_DATA);
  assign data_rd  = host_rd && (host_sel == REG_DATA);

  assign cap_block  = data_wr && (bank == BANK_INPUT);
  assign disp_block = data_wr && (bank != BANK_INPUT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bit IS_IN = (b == NUM_BANKS - 1);
    lut_bank #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
      .clk    (clk),
      .wr_en  (data_wr && (bank == 2'(b))),
      .hrd_en (data_rd && (bank == 2'(b))),
      .h_tbl  (host_tbl),
      .h_idx  (host_idx),
      .wr_data(host_wdata),
      .hrd_q  (hrd_q[b]),
      .px_en  (IS_IN ? cap_fire : disp_fire),
      .px_tbl (IS_IN ? in_sel : out_sel),
      .px_idx (IS_IN ? cap_in_data[ADDR_W-1:0] : disp_in_data[ADDR_W-1:0]),
      .px_q   (px_q[b])
    );
  end

  lut_pix_stage u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(cap_in_valid), .block(cap_block),
    .out_ready(cap_out_ready), .in_ready(cap_in_ready), .fire(cap_fire),
    .out_valid(cap_out_valid)
  );

  lut_pix_stage u_disp (
    .clk(clk), .rst_n(rst_n), .in_valid(disp_in_valid), .block(disp_block),
    .out_ready(disp_out_ready), .in_ready(disp_in_ready), .fire(disp_fire),
    .out_valid(disp_out_valid)
  );

  assign cap_out_data   = px_q[3];
  assign disp_out_red   = px_q[0];
  assign disp_out_green = px_q[1];
  assign disp_out_blue  = px_q[2];

  // Host read return: registers snapshot, data window via bank read register
  logic              rd_is_data_q;
  logic [1:0]        rd_bank_q;
  logic [BYTE_W-1:0] rd_reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_is_data_q <= 1'b0;
      rd_bank_q    <= '0;
      rd_reg_q     <= '0;
    end else if (host_rd) begin
      rd_is_data_q <= (host_sel == REG_DATA);
      rd_bank_q    <= bank;
      unique case (host_sel)
        REG_CTRL: rd_reg_q <= ctrl_q;
        REG_ADDR: rd_reg_q <= addr_q;
        default:  rd_reg_q <= '0;
      endcase
    end
  end

  assign host_rdata = rd_is_data_q ? hrd_q[rd_bank_q] : rd_reg_q;

  assert_cap_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == REG_DATA && ctrl_q[1:0] == BANK_INPUT) |-> !cap_in_ready);

  assert_disp_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == REG_DATA && ctrl_q[1:0] != BANK_INPUT) |-> !disp_in_ready);

  assert_cap_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_out_valid && !cap_out_ready) |=> $stable(cap_out_data));

  assert_disp_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_out_valid && !disp_out_ready) |=>
      ($stable(disp_out_red) && $stable(disp_out_green) && $stable(disp_out_blue)));
endmodule

// File: tb/tb_lut_port.sv
`timescale 1ns/1ps
module tb_lut_port;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 4;
  localparam int NT = 1 << SEL_W;
  localparam int NE = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic [1:0] host_sel = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic cap_in_valid = 0, cap_in_ready, cap_out_valid, cap_out_ready = 1;
  logic [7:0] cap_in_data = 0, cap_out_data;
  logic disp_in_valid = 0, disp_in_ready, disp_out_valid, disp_out_ready = 1;
  logic [7:0] disp_in_data = 0, disp_out_red, disp_out_green, disp_out_blue;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lut_port #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) dut (.*);

  function automatic logic [7:0] fval(int b, int t, int e);
    return 8'((b * 67 + t * 29 + e * 7 + 5) ^ 8'h3C);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] s, logic [7:0] d);
    @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); host_sel = s; host_rd = 1;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic push_cap(logic [7:0] px, logic [7:0] exp, string req);
    @(negedge clk); cap_in_valid = 1; cap_in_data = px;
    #1 chk(req, {7'd0, cap_in_ready}, 8'd1);
    @(negedge clk); cap_in_valid = 0;
    chk(req, {7'd0, cap_out_valid}, 8'd1);
    chk(req, cap_out_data, exp);
  endtask

  task automatic push_disp(logic [7:0] px, logic [7:0] er, logic [7:0] eg,
                           logic [7:0] eb, string req);
    @(negedge clk); disp_in_valid = 1; disp_in_data = px;
    #1 chk(req, {7'd0, disp_in_ready}, 8'd1);
    @(negedge clk); disp_in_valid = 0;
    chk(req, {7'd0, disp_out_valid}, 8'd1);
    chk(req, disp_out_red, er);
    chk(req, disp_out_green, eg);
    chk(req, disp_out_blue, eb);
  endtask

  function automatic logic [7:0] ctrl_of(int b, int ti, int to);
    return 8'(b | (ti << 2) | (to << 5));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rdata reset", host_rdata, 8'h00);
    chk("R1 cap_out_valid reset", {7'd0, cap_out_valid}, 8'd0);
    chk("R1 disp_out_valid reset", {7'd0, disp_out_valid}, 8'd0);
    hread(2'd0, r); chk("R1 ctrl reset", r, 8'h00);
    hread(2'd1, r); chk("R1 addr reset", r, 8'h00);
    // R1 readback of full bytes, sel 3 ignored
    hwrite(2'd0, 8'hA7); hread(2'd0, r); chk("R1 ctrl readback", r, 8'hA7);
    hwrite(2'd1, 8'h5E); hread(2'd1, r); chk("R1 addr readback", r, 8'h5E);
    hwrite(2'd3, 8'hFF);
    hread(2'd0, r); chk("R1 sel3 write ignored ctrl", r, 8'hA7);
    hread(2'd1, r); chk("R1 sel3 write ignored addr", r, 8'h5E);
    hread(2'd3, r); chk("R1 sel3 read zero", r, 8'h00);

    // R2 R3 R4 R5 R6: fill every table through the data window
    for (int b = 0; b < 4; b++)
      for (int t = 0; t < NT; t++) begin
        hwrite(2'd0, ctrl_of(b, t, t));
        for (int e = 0; e < NE; e++) begin
          hwrite(2'd1, 8'(e));
          hwrite(2'd2, fval(b, t, e));
        end
      end
    // R5 no auto-increment after data write and read
    hread(2'd1, r); chk("R5 addr after write", r, 8'(NE - 1));
    hread(2'd2, r); hread(2'd1, r); chk("R5 addr after read", r, 8'(NE - 1));

    // Read back: unused select bit 2 set, address upper bits set (ignored)
    for (int b = 0; b < 4; b++)
      for (int t = 0; t < NT; t++) begin
        hwrite(2'd0, ctrl_of(b, t | 4, t | 4));
        for (int e = 0; e < NE; e++) begin
          hwrite(2'd1, 8'((b << 4) | e | 8'h40));
          hread(2'd2, r);
          chk(b == 3 ? "R3 R6 input bank read" : "R2 R4 R6 colour bank read",
              r, fval(b, t, e));
        end
      end

    // R7 capture stream, every input table and pixel code
    for (int t = 0; t < NT; t++) begin
      hwrite(2'd0, ctrl_of(0, t, NT - 1 - t));
      for (int e = 0; e < NE; e++)
        push_cap(8'(e | 8'hA0), fval(3, t, e), "R7 R3 capture lookup");
    end

    // R8 display stream, every output table and pixel code
    for (int t = 0; t < NT; t++) begin
      hwrite(2'd0, ctrl_of(3, NT - 1 - t, t | 4));
      for (int e = 0; e < NE; e++)
        push_disp(8'(e | 8'h70), fval(0, t, e), fval(1, t, e), fval(2, t, e),
                  "R8 R4 display lookup");
    end

    // R9 back-pressure on capture
    hwrite(2'd0, ctrl_of(0, 1, 0));
    @(negedge clk); cap_out_ready = 0; cap_in_valid = 1; cap_in_data = 8'd2;
    @(negedge clk); cap_in_data = 8'd9;
    #1 chk("R9 in_ready low when full", {7'd0, cap_in_ready}, 8'd0);
    @(negedge clk); @(negedge clk);
    chk("R9 valid held", {7'd0, cap_out_valid}, 8'd1);
    chk("R9 data held", cap_out_data, fval(3, 1, 2));
    cap_out_ready = 1;
    #1 chk("R9 in_ready when draining", {7'd0, cap_in_ready}, 8'd1);
    @(negedge clk); cap_in_valid = 0;
    chk("R9 next pixel after drain", cap_out_data, fval(3, 1, 9));
    @(negedge clk);
    chk("R9 empty after drain", {7'd0, cap_out_valid}, 8'd0);

    // R9 back-pressure on display
    hwrite(2'd0, ctrl_of(0, 0, 2));
    @(negedge clk); disp_out_ready = 0; disp_in_valid = 1; disp_in_data = 8'd6;
    @(negedge clk); disp_in_valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 disp data held", disp_out_green, fval(1, 2, 6));
    chk("R9 disp valid held", {7'd0, disp_out_valid}, 8'd1);
    disp_out_ready = 1;
    @(negedge clk);

    // R10 host write to input bank stalls capture, not display
    hwrite(2'd0, ctrl_of(3, 2, 1));
    hwrite(2'd1, 8'd5);
    @(negedge clk); host_sel = 2'd2; host_wdata = 8'hE1; host_wr = 1;
    cap_in_valid = 1; cap_in_data = 8'd5;
    #1 chk("R10 capture stalled", {7'd0, cap_in_ready}, 8'd0);
    chk("R10 display free", {7'd0, disp_in_ready}, 8'd1);
    @(negedge clk); host_wr = 0;
    #1 chk("R10 capture resumes", {7'd0, cap_in_ready}, 8'd1);
    @(negedge clk); cap_in_valid = 0;
    chk("R10 capture sees new value", cap_out_data, 8'hE1);

    // R10 host write to green bank stalls display, not capture
    hwrite(2'd0, ctrl_of(1, 2, 1));
    @(negedge clk); host_sel = 2'd2; host_wdata = 8'h3B; host_wr = 1;
    disp_in_valid = 1; disp_in_data = 8'd5;
    #1 chk("R10 display stalled", {7'd0, disp_in_ready}, 8'd0);
    chk("R10 capture free", {7'd0, cap_in_ready}, 8'd1);
    @(negedge clk); host_wr = 0;
    @(negedge clk); disp_in_valid = 0;
    chk("R10 display sees new green", disp_out_green, 8'h3B);
    chk("R10 red unchanged", disp_out_red, fval(0, 1, 5));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule